// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block keeps every row of a DRAM with a fixed row count alive. An interval timer, derived from the clock frequency, marks when one more row refresh is owed. The sequencer asks a main memory controller for the strobe bus and, once granted, runs CAS-before-RAS (CBR) refresh cycles in which the DRAM takes the row address from its own counter. Refreshes that were owed while the bus was denied are counted up to a limit and then run back-to-back. A select input picks either the standard period (16 ms over all rows) or the extended low-power period (128 ms, 125 µs per row at 1024 rows).

On request the block puts the DRAM into self-refresh. It runs one CBR cycle and holds both strobes low for at least the minimum self-refresh hold time. When the request drops, it drives the row strobe high for the minimum self-refresh exit precharge. If the system was not refreshing in the distributed way before entry, it then runs a catch-up burst of one CBR cycle per row at minimum cycle time, and only after that does it release the bus.

FSM states: `ST_IDLE` (bus released), `ST_WAIT_GNT` (request raised), `ST_CAS_LEAD` (column strobe low ahead of the row strobe), `ST_RAS_LOW` (both strobes low), `ST_PRECHG` (both strobes high), `ST_SR_HOLD` (self-refresh, both strobes low), `ST_SR_EXIT` (row strobe high after self-refresh). Transitions:
- idle→wait when refresh is owed or self-refresh is requested.
- wait→cas_lead on grant.
- cas_lead→ras_low after the lead time.
- ras_low→sr_hold at the end of the entry cycle; ras_low→prechg otherwise.
- prechg→cas_lead while burst rows, owed refreshes or a self-refresh request remain; prechg→idle otherwise.
- sr_hold→sr_exit once the hold minimum has passed and the request has dropped.
- sr_exit→cas_lead to start the catch-up burst; sr_exit→idle in distributed mode.

Top module: `rfsh_sequencer`

## Requirements
- R1: After reset, ras_n=1, cas_n=1, bus_req=0, sr_active=0, catchup=0.
- R2: With ext_period=0 one refresh becomes owed every CLK_MHZ*1000*STD_MS/ROWS cycles. With ext_period=1 the interval is CLK_MHZ*1000*EXT_MS/ROWS cycles.
- R3: Every refresh cycle is CBR. cas_n goes low T_CSR cycles before ras_n. Both stay low for T_RAS cycles, then both stay high for T_RP cycles. ras_n is never low while cas_n is high.
- R4: bus_req rises when work is pending. The strobes stay high until bus_gnt is seen. bus_req stays high through all back-to-back cycles and falls with the last precharge. While bus_req is low, both strobes are high.
- R5: Owed refreshes accumulate up to MAX_DEBT, and further intervals are lost. After a grant the owed cycles run back-to-back with only T_RP of precharge between them.
- R6: A self-refresh request with nothing owed runs one CBR cycle, then holds both strobes low with sr_active=1. This lasts at least T_RASS cycles even if the request drops earlier.
- R7: Self-refresh ends with T_RPS cycles of ras_n=cas_n=1 while sr_active is still 1. sr_active then falls.
- R8: With distrib_mode=0, exit is followed by exactly ROWS back-to-back CBR cycles with catchup=1 and bus_req held. With distrib_mode=1, bus_req falls right after exit and no burst runs.
- R9: Refreshes owed when a self-refresh request arrives run before the entry cycle.
- R10: The timer and owed count are cleared during self-refresh and catch-up. The next refresh is owed one full interval after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_period | input | 1 | 1 selects the extended 128 ms refresh period |
| distrib_mode | input | 1 | 1 means distributed refresh was in use, so no burst is run after self-refresh |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| bus_gnt | input | 1 | Grant of the strobe bus from the main controller |
| bus_req | output | 1 | Request for the strobe bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| sr_active | output | 1 | DRAM is in self-refresh or its exit precharge |
| catchup | output | 1 | Post-exit refresh burst in progress |

## Verification
The main function is driven with an immediately granting controller under both periods, which separates the two interval lengths. A long grant denial separates a saturating owed count from one that wraps or drops everything. Self-refresh is entered with the request dropped early, which shows that the hold minimum is enforced independently of the request. Entry is also tried with refreshes still owed, which checks the ordering. Exits in both refresh modes distinguish the catch-up burst of exactly one cycle per row from an immediate bus release.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_CAS_LEAD,
        ST_RAS_LOW,
        ST_PRECHG,
        ST_SR_HOLD,
        ST_SR_EXIT
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int STD_LIM = 1953,
    parameter int EXT_LIM = 15625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic clr,
    output logic tick
);
    localparam int TW = $clog2(EXT_LIM + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim_m1;

    assign lim_m1 = ext_sel ? TW'(EXT_LIM - 1) : TW'(STD_LIM - 1);
    assign tick   = !clr && (cnt_q >= lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
    parameter int MAX_DEBT = 8,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          owe,
    input  logic          paid,
    output logic [DW-1:0] debt,
    output logic          pending
);
    logic at_cap;

    assign at_cap  = (debt == DW'(MAX_DEBT));
    assign pending = (debt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt <= '0;
        end else if (clr) begin
            debt <= '0;
        end else if (owe && !paid && !at_cap) begin
            debt <= debt + 1'b1;
        end else if (paid && !owe && pending) begin
            debt <= debt - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
    import rfsh_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int ROWS     = 1024,
    parameter int STD_MS   = 16,
    parameter int EXT_MS   = 128,
    parameter int T_CSR    = 2,
    parameter int T_RAS    = 7,
    parameter int T_RP     = 5,
    parameter int T_RASS   = 12500,
    parameter int T_RPS    = 14,
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_period,
    input  logic distrib_mode,
    input  logic sr_req,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic sr_active,
    output logic catchup
);
    localparam int STD_LIM = CLK_MHZ * 1000 * STD_MS / ROWS;
    localparam int EXT_LIM = CLK_MHZ * 1000 * EXT_MS / ROWS;
    localparam int DW      = $clog2(MAX_DEBT + 1);
    localparam int BW      = $clog2(ROWS + 1);
    localparam int M1      = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int M2      = (T_RP > T_RPS) ? T_RP : T_RPS;
    localparam int M3      = (M1 > M2) ? M1 : M2;
    localparam int PH_MAX  = (M3 > T_RASS) ? M3 : T_RASS;
    localparam int PW      = $clog2(PH_MAX + 1);

    rfsh_state_e   state_q, state_d;
    logic [PW-1:0] ph_q;
    logic          sr_go_q;
    logic [BW-1:0] burst_q;
    logic [DW-1:0] debt_q;
    logic          clr, tick, paid, pending, ras_end, pre_end, exit_end;

    assign clr      = (state_q == ST_SR_HOLD) || (state_q == ST_SR_EXIT) || (burst_q != '0);
    assign ras_end  = (state_q == ST_RAS_LOW) && (ph_q == PW'(T_RAS - 1));
    assign pre_end  = (state_q == ST_PRECHG)  && (ph_q == PW'(T_RP - 1));
    assign exit_end = (state_q == ST_SR_EXIT) && (ph_q == PW'(T_RPS - 1));
    assign paid     = ras_end && !sr_go_q && (burst_q == '0);

    rfsh_interval_timer #(.STD_LIM(STD_LIM), .EXT_LIM(EXT_LIM)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_period),
        .clr     (clr),
        .tick    (tick)
    );

    rfsh_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .owe     (tick),
        .paid    (paid),
        .debt    (debt_q),
        .pending (pending)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (pending || sr_req) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt) state_d = ST_CAS_LEAD;
            ST_CAS_LEAD: if (ph_q == PW'(T_CSR - 1)) state_d = ST_RAS_LOW;
            ST_RAS_LOW:  if (ras_end) state_d = sr_go_q ? ST_SR_HOLD : ST_PRECHG;
            ST_PRECHG:   if (pre_end) state_d = ((burst_q != '0) || pending || sr_req)
                                                ? ST_CAS_LEAD : ST_IDLE;
            ST_SR_HOLD:  if ((ph_q >= PW'(T_RASS - 1)) && !sr_req) state_d = ST_SR_EXIT;
            ST_SR_EXIT:  if (exit_end) state_d = distrib_mode ? ST_IDLE : ST_CAS_LEAD;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            sr_go_q <= 1'b0;
            burst_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)   ph_q <= '0;
            else if (ph_q != PW'(PH_MAX)) ph_q <= ph_q + 1'b1;

            if ((state_q == ST_WAIT_GNT) && bus_gnt)
                sr_go_q <= sr_req && !pending;
            else if (pre_end)
                sr_go_q <= (burst_q == '0) && !pending && sr_req;
            else if (state_q == ST_SR_EXIT)
                sr_go_q <= 1'b0;

            if (exit_end && !distrib_mode)  burst_q <= BW'(ROWS);
            else if (ras_end && (burst_q != '0)) burst_q <= burst_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b1;
        ras_n     = 1'b1;
        cas_n     = 1'b1;
        sr_active = 1'b0;
        unique case (state_q)
            ST_IDLE:     bus_req = 1'b0;
            ST_WAIT_GNT: ;
            ST_CAS_LEAD: cas_n = 1'b0;
            ST_RAS_LOW:  begin ras_n = 1'b0; cas_n = 1'b0; end
            ST_PRECHG:   ;
            ST_SR_HOLD:  begin ras_n = 1'b0; cas_n = 1'b0; sr_active = 1'b1; end
            ST_SR_EXIT:  sr_active = 1'b1;
            default:     bus_req = 1'b0;
        endcase
    end

    assign catchup = (burst_q != '0);
endmodule

// File: rtl/rfsh_sequencer_chk.sv
module rfsh_sequencer_chk #(
    parameter int MAX_DEBT = 8,
    localparam int DW = $clog2(MAX_DEBT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          ras_n,
    input logic          cas_n,
    input logic          sr_active,
    input logic          catchup,
    input logic [DW-1:0] debt
);
    assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    assert_cas_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    assert_strobes_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (ras_n && cas_n));

    assert_debt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        debt <= DW'(MAX_DEBT));

    assert_sr_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |-> (!ras_n && !cas_n && $past(!ras_n)));

    assert_sr_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> $past(ras_n && cas_n));

    assert_catchup_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        catchup |-> (bus_req && !sr_active));
endmodule

bind rfsh_sequencer rfsh_sequencer_chk #(.MAX_DEBT(MAX_DEBT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .sr_active (sr_active),
    .catchup   (catchup),
    .debt      (debt_q)
);

// File: tb/rfsh_sequencer_tb_top.sv
`timescale 1ns/1ps
module rfsh_sequencer_tb_top;
    localparam int CLK_MHZ = 1, ROWS = 16, STD_MS = 16, EXT_MS = 128;
    localparam int T_CSR = 2, T_RAS = 4, T_RP = 3, T_RASS = 20, T_RPS = 5, MAX_DEBT = 4;
    localparam int STD_LIM = CLK_MHZ * 1000 * STD_MS / ROWS;
    localparam int EXT_LIM = CLK_MHZ * 1000 * EXT_MS / ROWS;
    localparam int RL = T_CSR + T_RAS;
    localparam int L  = RL + T_RP;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_period = 1'b0, distrib_mode = 1'b1, sr_req = 1'b0, bus_gnt = 1'b0;
    logic bus_req, ras_n, cas_n, sr_active, catchup;
    logic block_gnt = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cbr_cnt = 0, req_fall = 0, sr_len = 0, last_sr_len = 0;
    logic prev_cas = 1'b1, prev_req = 1'b0;

    always #4 clk = ~clk;

    rfsh_sequencer #(
        .CLK_MHZ(CLK_MHZ), .ROWS(ROWS), .STD_MS(STD_MS), .EXT_MS(EXT_MS),
        .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RASS(T_RASS),
        .T_RPS(T_RPS), .MAX_DEBT(MAX_DEBT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_period(ext_period), .distrib_mode(distrib_mode),
        .sr_req(sr_req), .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n),
        .cas_n(cas_n), .sr_active(sr_active), .catchup(catchup)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 idle, 1 awaiting grant, 2 inside a CBR pattern, 3 self-refresh hold, 4 exit precharge
    int m_tmr, m_debt, m_mode, m_pos, m_hold, m_burst, m_lim, m_d0;
    bit m_sr, m_clr, m_tick, m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_debt = 0; m_mode = 0; m_pos = 0; m_hold = 0; m_burst = 0; m_sr = 0;
        end else begin
            m_lim  = ext_period ? EXT_LIM : STD_LIM;
            m_clr  = (m_mode >= 3) || (m_burst > 0);
            m_tick = !m_clr && (m_tmr >= m_lim - 1);
            m_done = (m_mode == 2) && (m_pos == RL - 1) && !m_sr && (m_burst == 0);
            m_d0   = m_debt;
            m_tmr  = (m_clr || m_tick) ? 0 : m_tmr + 1;
            if (m_clr) m_debt = 0;
            else if (m_tick && !m_done && m_debt < MAX_DEBT) m_debt++;
            else if (m_done && !m_tick && m_debt > 0) m_debt--;
            case (m_mode)
                0: if (m_d0 > 0 || sr_req) m_mode = 1;
                1: if (bus_gnt) begin m_mode = 2; m_pos = 0; m_sr = sr_req && (m_d0 == 0); end
                2: begin
                    if (m_pos == RL - 1 && m_sr) begin
                        m_mode = 3; m_hold = 0;
                    end else if (m_pos == L - 1) begin
                        m_pos = 0;
                        if (m_burst > 0)      m_sr = 0;
                        else if (m_d0 > 0)    m_sr = 0;
                        else if (sr_req)      m_sr = 1;
                        else begin m_sr = 0; m_mode = 0; end
                    end else begin
                        if (m_pos == RL - 1 && m_burst > 0) m_burst--;
                        m_pos++;
                    end
                end
                3: if (m_hold >= T_RASS - 1 && !sr_req) begin m_mode = 4; m_hold = 0; end
                   else if (m_hold < T_RASS - 1) m_hold++;
                4: if (m_hold == T_RPS - 1) begin
                       m_sr = 0;
                       if (distrib_mode) m_mode = 0;
                       else begin m_mode = 2; m_pos = 0; m_burst = ROWS; end
                   end else m_hold++;
                default: m_mode = 0;
            endcase
        end
    end

    // per-cycle comparison and grant driver, away from the active edge
    always @(negedge clk) begin
        logic e_req, e_ras, e_cas, e_sr;
        if (rst_n) begin
            e_req = (m_mode != 0);
            e_sr  = (m_mode >= 3);
            e_ras = !((m_mode == 3) || (m_mode == 2 && m_pos >= T_CSR && m_pos < RL));
            e_cas = !((m_mode == 3) || (m_mode == 2 && m_pos < RL));
            chk(bus_req == e_req, "R4 bus_req", bus_req, e_req);
            chk(ras_n == e_ras, "R3 ras_n", ras_n, e_ras);
            chk(cas_n == e_cas, "R3 cas_n", cas_n, e_cas);
            chk(sr_active == e_sr, "R6/R7 sr_active", sr_active, e_sr);
            chk(catchup == (m_burst > 0), "R8 catchup", catchup, m_burst > 0);
        end
        bus_gnt <= block_gnt ? 1'b0 : bus_req;
    end

    // edge monitors sampled just after the active edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (prev_cas && !cas_n) cbr_cnt++;
        if (prev_req && !bus_req) req_fall++;
        if (sr_active) sr_len++;
        else if (sr_len != 0) begin last_sr_len = sr_len; sr_len = 0; end
        prev_cas = cas_n;
        prev_req = bus_req;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base, rf, k, d_exp;
        wait_n(3);
        chk(ras_n == 1 && cas_n == 1, "R1 strobes at reset", {ras_n, cas_n}, 3);
        chk(bus_req == 0 && sr_active == 0 && catchup == 0, "R1 control at reset",
            {bus_req, sr_active, catchup}, 0);
        rst_n = 1'b1;

        // R2 standard period
        base = cbr_cnt;
        wait_n(2500);
        chk(cbr_cnt - base == 2, "R2 standard interval refreshes", cbr_cnt - base, 2);

        // R2 extended period
        ext_period = 1'b1;
        base = cbr_cnt;
        wait_n(17000);
        chk(cbr_cnt - base == 2, "R2 extended interval refreshes", cbr_cnt - base, 2);
        ext_period = 1'b0;

        // R5 saturation and back-to-back issue, R4 hold of bus
        block_gnt = 1'b1;
        base = cbr_cnt;
        wait_n(7000);
        chk(cbr_cnt == base, "R4 no strobes without grant", cbr_cnt - base, 0);
        rf = req_fall;
        block_gnt = 1'b0;
        wait_n(200);
        chk(cbr_cnt - base == MAX_DEBT, "R5 capped owed refreshes", cbr_cnt - base, MAX_DEBT);
        chk(req_fall - rf == 1, "R5 back-to-back under one request", req_fall - rf, 1);

        // R6/R7 self-refresh with early request drop, distributed mode (R8)
        distrib_mode = 1'b1;
        sr_req = 1'b1;
        k = 0;
        while (!sr_active && k < 3000) begin @(negedge clk); k++; end
        chk(sr_active == 1, "R6 self-refresh entered", sr_active, 1);
        wait_n(3);
        sr_req = 1'b0;
        base = cbr_cnt;
        k = 0;
        while (sr_active && k < 200) begin @(negedge clk); k++; end
        @(negedge clk);
        chk(last_sr_len == T_RASS + T_RPS, "R6/R7 self-refresh duration", last_sr_len, T_RASS + T_RPS);
        chk(bus_req == 0, "R8 bus released after distributed exit", bus_req, 0);
        // R10 restart of interval after return
        k = 1;
        while (!bus_req && k < 3000) begin @(negedge clk); k++; end
        chk(k >= STD_LIM - 5 && k <= STD_LIM + 10, "R10 full interval after exit", k, STD_LIM + 1);
        wait_n(30);
        chk(cbr_cnt - base == 1, "R8 no burst in distributed mode", cbr_cnt - base, 1);

        // R9 owed refreshes before entry, then R8 catch-up burst
        wait_n(200);
        block_gnt = 1'b1;
        wait_n(2100);
        sr_req = 1'b1;
        distrib_mode = 1'b0;
        d_exp = m_debt;
        base = cbr_cnt;
        block_gnt = 1'b0;
        k = 0;
        while (!sr_active && k < 500) begin @(negedge clk); k++; end
        chk(cbr_cnt - base == d_exp + 1, "R9 owed cycles ahead of entry", cbr_cnt - base, d_exp + 1);
        sr_req = 1'b0;
        base = cbr_cnt;
        k = 0;
        while ((sr_active || catchup) && k < 2000) begin @(negedge clk); k++; end
        wait_n(T_RP + 2);
        chk(cbr_cnt - base == ROWS, "R8 catch-up burst length", cbr_cnt - base, ROWS);
        chk(bus_req == 0, "R8 bus released after burst", bus_req, 0);

        wait_n(50);
        finish_run();
    end
endmodule